// File: doc/BRIEF.md
# Universal Bus Transceiver Register

This block is a two-way register slice between an A port and a B port. Each direction has one storage register that runs in one of three modes: transparent, hold, or capture on a falling edge of that direction's control clock. Each direction also has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low. The datapath is built from independent halves (two halves of 18 bits by default). Each half has its own six control inputs.

All data and control inputs are sampled on the fast system clock `clk_i`, and outputs change one `clk_i` cycle after the inputs that cause them. The control clock is a sampled signal, not a clock net. A falling edge means the previous sample was 1 and the current sample is 0. Every port is split into a data input, a data output and an output-enable flag. An enable flag of 0 means that side is in high impedance. A pad wrapper resolves these signals onto the physical bidirectional nets.

Top module: `ubt_xcvr`

## Requirements
- R1: While a direction's latch enable is 1, its destination output equals the source data sampled one `clk_i` cycle earlier (transparent).
- R2: While latch enable is 0 and no falling edge of that direction's control clock occurs, the destination output keeps its value, whatever the source data does. A rising edge is one such case.
- R3: While latch enable is 0, a falling edge of the control clock (sample 1 followed by sample 0) loads the source data seen in that same sample, visible one cycle later.
- R4: The A-to-B enable `ab_oe_i` is active high. `b_oe_o` takes its value one cycle later, and `b_oe_o`=0 means the B side is high impedance.
- R5: The B-to-A enable `ba_oe_ni` is active low. `a_oe_o` equals its inverse one cycle later, and `a_oe_o`=0 means the A side is high impedance.
- R6: The output enable does not affect storage. Data loaded while the output is disabled appears on the output once it is enabled.
- R7: Half h uses data bits [h*18 +: 18] and control bit h only. Activity in one half leaves the other half's outputs unchanged.
- R8: If latch enable falls while the control clock is 1, the last transparent value is held until the next falling edge, which loads new data.
- R9: The active-low asynchronous reset `rst_ni` clears all storage to zero and clears both enable flags (high impedance).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system sampling clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| a_i | input | 36 | data arriving on the A side |
| a_o | output | 36 | data driven onto the A side |
| a_oe_o | output | 2 | per-half drive enable for A, 0 = high impedance |
| b_i | input | 36 | data arriving on the B side |
| b_o | output | 36 | data driven onto the B side |
| b_oe_o | output | 2 | per-half drive enable for B, 0 = high impedance |
| ab_oe_i | input | 2 | A-to-B output enable per half, active high |
| ba_oe_ni | input | 2 | B-to-A output enable per half, active low |
| ab_le_i | input | 2 | A-to-B latch enable per half |
| ba_le_i | input | 2 | B-to-A latch enable per half |
| ab_ck_i | input | 2 | A-to-B control clock per half |
| ba_ck_i | input | 2 | B-to-A control clock per half |

## Verification
A vector table runs the A-to-B path of one half through a sequence of input patterns:
- Transparent steps show that the output follows the source.
- Steady-clock and rising-clock steps with new data separate hold from capture.
- A latch enable that falls while the clock is high, followed later by a falling edge, separates the deferred capture from an immediate load.

Directed tests then cover:
- enable polarity in each direction;
- loading while the output is disabled;
- the B-to-A path in the other half;
- isolation between halves, shown by activity in one half while the other half holds a distinct value;
- reset in the middle of a run.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  localparam int unsigned UBT_HALF_W = 18;
  localparam int unsigned UBT_N_HALF = 2;

  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_PASS    = 2'd1,
    MODE_CAPTURE = 2'd2
  } store_mode_e;
endpackage

// File: rtl/ubt_store.sv
module ubt_store
  import ubt_pkg::*;
#(
  parameter int unsigned W = UBT_HALF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic         ck_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic         ck_q;
  logic [W-1:0] st_q;
  store_mode_e  mode;

  // falling edge = previous sample high, current sample low
  always_comb begin
    if (le_i)              mode = MODE_PASS;
    else if (ck_q && !ck_i) mode = MODE_CAPTURE;
    else                   mode = MODE_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_q <= 1'b0;
      st_q <= '0;
    end else begin
      ck_q <= ck_i;
      if (mode != MODE_HOLD) st_q <= d_i;
    end
  end

  assign q_o = st_q;

  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> (q_o == $past(d_i))); // R1
  AST_HOLD_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && !(ck_q && !ck_i)) |=> $stable(q_o)); // R2
  AST_FALL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && ck_q && !ck_i) |=> (q_o == $past(d_i))); // R3

endmodule

// File: rtl/ubt_slice.sv
module ubt_slice
  import ubt_pkg::*;
#(
  parameter int unsigned W = UBT_HALF_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o,
  input  logic         ab_oe_i,
  input  logic         ba_oe_ni,
  input  logic         ab_le_i,
  input  logic         ba_le_i,
  input  logic         ab_ck_i,
  input  logic         ba_ck_i
);

  logic a_oe_q, b_oe_q;

  ubt_store #(.W(W)) i_ab (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .le_i  (ab_le_i),
    .ck_i  (ab_ck_i),
    .d_i   (a_i),
    .q_o   (b_o)
  );

  ubt_store #(.W(W)) i_ba (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .le_i  (ba_le_i),
    .ck_i  (ba_ck_i),
    .d_i   (b_i),
    .q_o   (a_o)
  );

  // enables are sampled like data so drive and value change together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_oe_q <= 1'b0;
      b_oe_q <= 1'b0;
    end else begin
      b_oe_q <= ab_oe_i;
      a_oe_q <= ~ba_oe_ni;
    end
  end

  assign a_oe_o = a_oe_q;
  assign b_oe_o = b_oe_q;

  AST_AB_EN_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_oe_i |=> b_oe_o); // R4
  AST_AB_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ab_oe_i |=> !b_oe_o); // R4
  AST_BA_EN_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ba_oe_ni |=> a_oe_o); // R5
  AST_BA_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_oe_ni |=> !a_oe_o); // R5

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
  import ubt_pkg::*;
#(
  parameter int unsigned HALF_W = UBT_HALF_W,
  parameter int unsigned N_HALF = UBT_N_HALF,
  localparam int unsigned BUS_W = HALF_W * N_HALF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_W-1:0]  a_i,
  output logic [BUS_W-1:0]  a_o,
  output logic [N_HALF-1:0] a_oe_o,
  input  logic [BUS_W-1:0]  b_i,
  output logic [BUS_W-1:0]  b_o,
  output logic [N_HALF-1:0] b_oe_o,
  input  logic [N_HALF-1:0] ab_oe_i,
  input  logic [N_HALF-1:0] ba_oe_ni,
  input  logic [N_HALF-1:0] ab_le_i,
  input  logic [N_HALF-1:0] ba_le_i,
  input  logic [N_HALF-1:0] ab_ck_i,
  input  logic [N_HALF-1:0] ba_ck_i
);

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    ubt_slice #(.W(HALF_W)) i_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .a_i     (a_i[h*HALF_W +: HALF_W]),
      .a_o     (a_o[h*HALF_W +: HALF_W]),
      .a_oe_o  (a_oe_o[h]),
      .b_i     (b_i[h*HALF_W +: HALF_W]),
      .b_o     (b_o[h*HALF_W +: HALF_W]),
      .b_oe_o  (b_oe_o[h]),
      .ab_oe_i (ab_oe_i[h]),
      .ba_oe_ni(ba_oe_ni[h]),
      .ab_le_i (ab_le_i[h]),
      .ba_le_i (ba_le_i[h]),
      .ab_ck_i (ab_ck_i[h]),
      .ba_ck_i (ba_ck_i[h])
    );
  end

  // R7: per-half isolation comes from the slice partitioning above
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (a_oe_o == '0 && b_oe_o == '0 && a_o == '0 && b_o == '0)); // R9

endmodule

// File: tb/test_ubt_xcvr.sv
module test_ubt_xcvr;
  localparam int unsigned HW = 18;
  localparam int unsigned NH = 2;
  localparam int unsigned BW = HW * NH;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [BW-1:0] a_i = '0, b_i = '0;
  logic [BW-1:0] a_o, b_o;
  logic [NH-1:0] a_oe_o, b_oe_o;
  logic [NH-1:0] ab_oe_i = '0, ba_oe_ni = '1;
  logic [NH-1:0] ab_le_i = '0, ba_le_i = '0, ab_ck_i = '0, ba_ck_i = '0;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i; // 250 MHz

  ubt_xcvr i_ubt_xcvr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o),
    .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe_o),
    .ab_oe_i(ab_oe_i), .ba_oe_ni(ba_oe_ni),
    .ab_le_i(ab_le_i), .ba_le_i(ba_le_i),
    .ab_ck_i(ab_ck_i), .ba_ck_i(ba_ck_i)
  );

  // {le, ck, a half0, expected b half0}
  localparam logic [37:0] VEC [10] = '{
    {1'b1, 1'b0, 18'h12345, 18'h12345}, // R1
    {1'b1, 1'b1, 18'h0ABCD, 18'h0ABCD}, // R1
    {1'b0, 1'b1, 18'h3FFFF, 18'h0ABCD}, // R8 le falls, ck high
    {1'b0, 1'b0, 18'h15555, 18'h15555}, // R8 next fall loads
    {1'b0, 1'b0, 18'h2AAAA, 18'h15555}, // R2
    {1'b0, 1'b1, 18'h2AAAA, 18'h15555}, // R2 rising edge
    {1'b0, 1'b1, 18'h00F0F, 18'h15555}, // R2
    {1'b0, 1'b0, 18'h00F0F, 18'h00F0F}, // R3
    {1'b1, 1'b0, 18'h3C3C3, 18'h3C3C3}, // R1
    {1'b0, 1'b0, 18'h11111, 18'h3C3C3}  // R2 ck low when le fell
  };

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    step(); step();
    chk("R9 reset b_o", 64'(b_o), 64'h0);
    chk("R9 reset a_o", 64'(a_o), 64'h0);
    chk("R9 reset oe", 64'({a_oe_o, b_oe_o}), 64'h0);
    rst_ni = 1'b1;
    ab_oe_i = 2'b11;
    step();
    chk("R4 b_oe on", 64'(b_oe_o), 64'h3);
    chk("R5 a_oe off", 64'(a_oe_o), 64'h0);

    for (int i = 0; i < 10; i++) begin
      ab_le_i[0] = VEC[i][37];
      ab_ck_i[0] = VEC[i][36];
      a_i[17:0]  = VEC[i][35:18];
      step();
      chk($sformatf("R1/R2/R3/R8 vec%0d", i), 64'(b_o[17:0]), 64'(VEC[i][17:0]));
    end

    // R6: load while disabled
    ab_oe_i[0] = 1'b0; ab_le_i[0] = 1'b1; a_i[17:0] = 18'h2468A;
    step();
    chk("R4 b_oe off", 64'(b_oe_o[0]), 64'h0);
    ab_le_i[0] = 1'b0; a_i[17:0] = 18'h00001;
    step();
    ab_oe_i[0] = 1'b1;
    step();
    chk("R6 stored after enable", 64'(b_o[17:0]), 64'h2468A);
    chk("R6 enable back", 64'(b_oe_o[0]), 64'h1);

    // R7: half isolation
    ab_le_i[1] = 1'b1; a_i[35:18] = 18'h1357A;
    step();
    ab_le_i[1] = 1'b0; a_i[35:18] = 18'h0;
    step();
    ab_le_i[0] = 1'b1; a_i[17:0] = 18'h3FFFF;
    step();
    ab_le_i[0] = 1'b0; ab_ck_i[0] = 1'b1;
    step();
    ab_ck_i[0] = 1'b0; a_i[17:0] = 18'h00077;
    step();
    chk("R3 half0 load", 64'(b_o[17:0]), 64'h00077);
    chk("R7 half1 untouched", 64'(b_o[35:18]), 64'h1357A);

    // B-to-A in half1
    ba_oe_ni[1] = 1'b0; ba_le_i[1] = 1'b1; b_i[35:18] = 18'h0BEEF;
    step();
    chk("R5 a_oe on", 64'(a_oe_o), 64'h2);
    chk("R1 ba pass", 64'(a_o[35:18]), 64'h0BEEF);
    ba_le_i[1] = 1'b0; ba_ck_i[1] = 1'b1;
    step();
    b_i[35:18] = 18'h01234;
    step();
    chk("R2 ba hold", 64'(a_o[35:18]), 64'h0BEEF);
    ba_ck_i[1] = 1'b0;
    step();
    chk("R3 ba load", 64'(a_o[35:18]), 64'h01234);
    chk("R7 half0 a side", 64'(a_o[17:0]), 64'h0);
    ba_oe_ni[1] = 1'b1;
    step();
    chk("R5 a_oe off", 64'(a_oe_o[1]), 64'h0);

    // R9 reset mid-run
    rst_ni = 1'b0;
    step();
    chk("R9 mid reset b_o", 64'(b_o), 64'h0);
    chk("R9 mid reset a_o", 64'(a_o), 64'h0);
    chk("R9 mid reset b_oe", 64'(b_oe_o), 64'h0);
    rst_ni = 1'b1;
    step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule